// File: doc/BRIEF.md
# Internal Data Memory Address Router

This block sits between the core's internal data address bus and two kinds of storage: a 256-byte on-chip data RAM and the special function register (SFR) space. Each byte access has an 8-bit address, a flag giving the addressing mode, and a read or write strobe. The block sends the access to one target and returns the read data.

The lower half of the address range, 00H to 7FH, always reaches the lower RAM. The upper half, 80H to FFH, is overlaid. A direct-mode access there reaches an SFR. An indirect-mode access there, which includes stack pushes and pops, reaches a separate upper RAM byte at the same address. The block holds both RAM halves itself. The SFRs sit outside it behind a plain register-file port: an address, a read strobe, a write strobe, write data and returned read data.

A parameter mask states which SFR addresses exist. The block discards a direct write to an address that does not exist and returns 00H for a read of one. This keeps simulation deterministic.

Top module: `dmem_router`

## Requirements
- R1: An access to 00H–7FH selects the lower RAM (`sel_lo_ram`=1) in both modes. A byte written in one mode reads back in the other.
- R2: At most one of `sel_lo_ram`, `sel_hi_ram`, `sel_sfr` is high. None is high while both `rd_en` and `wr_en` are low. `rd_data` is 00H whenever `rd_en` is low.
- R3: A direct access (`ind_mode`=0) to an implemented address in 80H–FFH raises `sel_sfr` and drives `sfr_addr` with address bits [6:0]. A write raises `sfr_wr_en` with `sfr_wdata`=`wr_data`. A read raises `sfr_rd_en` and returns `sfr_rdata` on `rd_data`.
- R4: An indirect access (`ind_mode`=1) to 80H–FFH selects the upper RAM (`sel_hi_ram`=1) and never raises `sfr_rd_en` or `sfr_wr_en`.
- R5: The upper RAM and the SFR space are separate storage. A direct write to an address leaves the upper RAM byte at that address unchanged. An indirect write leaves the SFR at that address unchanged.
- R6: A direct access to an unimplemented SFR address raises no select and no SFR strobe. A write is discarded: no RAM or SFR byte changes. A read returns 00H.
- R7: With the default `SFR_MAP`, 80H–8FH are implemented, and so is every address in 90H–FFH whose bits [2:0] are zero. Every other address from 90H up is unimplemented. Bit k of `SFR_MAP` stands for address 80H+k.
- R8: A write commits on the rising clock edge during which `wr_en` is high. Reads are combinational from the address in the same cycle.
- R9: In reset, with no strobe applied, all selects and SFR strobes are low and `rd_data` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Internal data address |
| ind_mode | input | 1 | 1 = indirect addressing, 0 = direct |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| sel_lo_ram | output | 1 | Lower RAM selected |
| sel_hi_ram | output | 1 | Upper RAM selected |
| sel_sfr | output | 1 | SFR space selected |
| sfr_addr | output | 7 | SFR register index (address bits [6:0]) |
| sfr_rd_en | output | 1 | SFR read strobe |
| sfr_wr_en | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data returned |

## Verification
The hardest case is showing that the two storages at one overlaid address really are independent. A single access cannot show it. The stimulus therefore writes distinct patterns to the same upper address, once directly and once indirectly, and reads both back in each mode. The bench's SFR model proves the indirect write never reached the SFR, and the upper RAM readback proves the direct write never reached the RAM. The same read-after-write step follows a discarded write to an unimplemented address, so its absence of effect is visible at the ports.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_LO_RAM = 2'd1,
    TGT_HI_RAM = 2'd2,
    TGT_SFR    = 2'd3
  } tgt_e;

  // Implemented SFR set: 80H-8FH plus every 8-aligned address above.
  function automatic logic [127:0] default_sfr_map();
    logic [127:0] m;
    for (int k = 0; k < 128; k++) begin
      m[k] = (k < 16) || (k[2:0] == 3'd0);
    end
    return m;
  endfunction

endpackage

// File: rtl/dmem_router_decode.sv
module dmem_router_decode
  import dmem_router_pkg::*;
#(
  parameter int AW   = 8,
  localparam int HALF = 2 ** (AW - 1)
) (
  input  logic [AW-1:0] addr,
  input  logic          ind_mode,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [HALF-1:0] sfr_map,
  output tgt_e          tgt
);

  logic access;
  logic upper;
  logic impl;

  always_comb begin
    access = rd_en | wr_en;
    upper  = addr[AW-1];
    impl   = sfr_map[addr[AW-2:0]];
    tgt    = TGT_NONE;
    if (access) begin
      if (!upper)        tgt = TGT_LO_RAM;
      else if (ind_mode) tgt = TGT_HI_RAM;
      else if (impl)     tgt = TGT_SFR;
    end
  end

endmodule

// File: rtl/dmem_router_ram.sv
module dmem_router_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int HALF = 2 ** (AW - 1),
  localparam int IW   = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_we,
  input  logic          bank_rsel,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [HALF];

    always_ff @(posedge clk) begin
      if (bank_we[b]) mem[idx] <= wdata;
    end

    always_comb bank_rd[b] = mem[idx];

    a_r8_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we[b] |=> (mem[$past(idx)] == $past(wdata)));
  end

  always_comb rdata = bank_rd[bank_rsel];

  a_r5_one_bank_written: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_we) <= 1);

endmodule

// File: rtl/dmem_router_rdmux.sv
module dmem_router_rdmux
  import dmem_router_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rd_en,
  input  tgt_e          tgt,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] sfr_rdata,
  output logic [DW-1:0] rd_data
);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (tgt)
        TGT_LO_RAM, TGT_HI_RAM: rd_data = ram_rdata;
        TGT_SFR:                rd_data = sfr_rdata;
        default:                rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_router_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [127:0] SFR_MAP = default_sfr_map()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ind_mode,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sel_lo_ram,
  output logic          sel_hi_ram,
  output logic          sel_sfr,
  output logic [AW-2:0] sfr_addr,
  output logic          sfr_rd_en,
  output logic          sfr_wr_en,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);

  localparam int HALF = 2 ** (AW - 1);

  tgt_e       tgt;
  logic [1:0] bank_we;
  logic [DW-1:0] ram_rdata;

  dmem_router_decode #(.AW(AW)) decode_i (
    .addr     (addr),
    .ind_mode (ind_mode),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .sfr_map  (SFR_MAP[HALF-1:0]),
    .tgt      (tgt)
  );

  always_comb begin
    sel_lo_ram = (tgt == TGT_LO_RAM);
    sel_hi_ram = (tgt == TGT_HI_RAM);
    sel_sfr    = (tgt == TGT_SFR);
    bank_we    = {sel_hi_ram & wr_en, sel_lo_ram & wr_en};
    sfr_addr   = addr[AW-2:0];
    sfr_rd_en  = sel_sfr & rd_en;
    sfr_wr_en  = sel_sfr & wr_en;
    sfr_wdata  = wr_data;
  end

  dmem_router_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_we   (bank_we),
    .bank_rsel (addr[AW-1]),
    .idx       (addr[AW-2:0]),
    .wdata     (wr_data),
    .rdata     (ram_rdata)
  );

  dmem_router_rdmux #(.DW(DW)) rdmux_i (
    .rd_en     (rd_en),
    .tgt       (tgt),
    .ram_rdata (ram_rdata),
    .sfr_rdata (sfr_rdata),
    .rd_data   (rd_data)
  );

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_lo_ram, sel_hi_ram, sel_sfr}));

  a_r4_indirect_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_mode && addr[AW-1]) |-> !(sfr_rd_en || sfr_wr_en));

  a_r5_sfr_write_spares_ram: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr_en |-> (bank_we == 2'b00));

  a_r6_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ind_mode && addr[AW-1] && !sel_sfr) |-> (rd_data == '0));

  a_r1_lower_in_any_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !addr[AW-1]) |-> sel_lo_ram);

endmodule

// File: tb/dmem_router_tb_top.sv
module dmem_router_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       ind_mode = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sel_lo_ram, sel_hi_ram, sel_sfr;
  logic [6:0] sfr_addr;
  logic       sfr_rd_en, sfr_wr_en;
  logic [7:0] sfr_wdata, sfr_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dmem_router dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ind_mode(ind_mode),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sel_lo_ram(sel_lo_ram), .sel_hi_ram(sel_hi_ram), .sel_sfr(sel_sfr),
    .sfr_addr(sfr_addr), .sfr_rd_en(sfr_rd_en), .sfr_wr_en(sfr_wr_en),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // Bench-side SFR register file
  logic [7:0] sfr_model [128];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) sfr_model[i] <= 8'h00;
    end else if (sfr_wr_en) begin
      sfr_model[sfr_addr] <= sfr_wdata;
    end
  end
  assign sfr_rdata = sfr_model[sfr_addr];

  function automatic bit exp_impl(input logic [7:0] a);
    return (a[7:4] == 4'h8) || (a[2:0] == 3'd0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One write cycle; captures the strobes seen during it.
  logic cap_sel_lo, cap_sel_hi, cap_sel_sfr, cap_sfr_wr, cap_sfr_rd;
  task automatic do_wr(input logic [7:0] a, input logic ind, input logic [7:0] d);
    @(negedge clk);
    addr = a; ind_mode = ind; wr_data = d; wr_en = 1'b1;
    #1;
    cap_sel_lo = sel_lo_ram; cap_sel_hi = sel_hi_ram; cap_sel_sfr = sel_sfr;
    cap_sfr_wr = sfr_wr_en; cap_sfr_rd = sfr_rd_en;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic ind, output logic [7:0] d);
    @(negedge clk);
    addr = a; ind_mode = ind; rd_en = 1'b1;
    #1;
    d = rd_data;
    cap_sel_lo = sel_lo_ram; cap_sel_hi = sel_hi_ram; cap_sel_sfr = sel_sfr;
    cap_sfr_wr = sfr_wr_en; cap_sfr_rd = sfr_rd_en;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R9 selects in reset", {sel_lo_ram, sel_hi_ram, sel_sfr}, 3'b000);
    chk("R9 sfr strobes in reset", {sfr_rd_en, sfr_wr_en}, 2'b00);
    chk("R9 rd_data in reset", rd_data, 8'h00);
  endtask

  task automatic t_lower();
    logic [7:0] d;
    do_wr(8'h05, 1'b0, 8'h3C);
    chk("R1 direct write lower sel", cap_sel_lo, 1'b1);
    do_rd(8'h05, 1'b1, d);
    chk("R1 indirect readback", d, 8'h3C);
    do_wr(8'h7F, 1'b1, 8'hA5);
    do_rd(8'h7F, 1'b0, d);
    chk("R1 direct readback of 7FH", d, 8'hA5);
    chk("R1 lower select on read", {cap_sel_lo, cap_sel_hi, cap_sel_sfr}, 3'b100);
  endtask

  task automatic t_idle();
    @(negedge clk);
    addr = 8'hA0; ind_mode = 1'b0; #1;
    chk("R2 no select without strobe", {sel_lo_ram, sel_hi_ram, sel_sfr}, 3'b000);
    chk("R2 rd_data idle", rd_data, 8'h00);
  endtask

  task automatic t_sfr_direct();
    logic [7:0] d;
    do_wr(8'hA0, 1'b0, 8'h5A);
    chk("R3 sfr write strobe", {cap_sel_sfr, cap_sfr_wr}, 2'b11);
    chk("R3 sfr model updated", sfr_model[7'h20], 8'h5A);
    do_rd(8'hA0, 1'b0, d);
    chk("R3 sfr readback", d, 8'h5A);
    chk("R3 sfr read strobe", cap_sfr_rd, 1'b1);
  endtask

  task automatic t_overlay();
    logic [7:0] d;
    do_wr(8'hA0, 1'b1, 8'hC3);
    chk("R4 indirect select upper ram", {cap_sel_hi, cap_sfr_wr}, 2'b10);
    chk("R5 sfr untouched by indirect", sfr_model[7'h20], 8'h5A);
    do_wr(8'hA0, 1'b0, 8'h11);
    do_rd(8'hA0, 1'b1, d);
    chk("R5 upper ram untouched by direct", d, 8'hC3);
    do_rd(8'hA0, 1'b0, d);
    chk("R5 sfr holds direct value", d, 8'h11);
    // stack-style region near top
    do_wr(8'hFF, 1'b1, 8'h77);
    do_rd(8'hFF, 1'b1, d);
    chk("R4 top byte upper ram", d, 8'h77);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    chk("R7 map 91H unimplemented", exp_impl(8'h91), 1'b0);
    do_wr(8'h91, 1'b1, 8'h9E);
    do_wr(8'h91, 1'b0, 8'h42);
    chk("R6 no strobe on unimpl write", {cap_sel_lo, cap_sel_hi, cap_sel_sfr, cap_sfr_wr}, 4'b0000);
    chk("R6 sfr model unchanged", sfr_model[7'h11], 8'h00);
    do_rd(8'h91, 1'b1, d);
    chk("R6 upper ram unchanged", d, 8'h9E);
    do_rd(8'h91, 1'b0, d);
    chk("R6 unimpl read zero", d, 8'h00);
    chk("R6 no sfr read strobe", {cap_sel_sfr, cap_sfr_rd}, 2'b00);
  endtask

  task automatic t_map();
    logic [7:0] d;
    for (int a = 8'h80; a <= 8'hFF; a++) begin
      @(negedge clk);
      addr = a[7:0]; ind_mode = 1'b0; rd_en = 1'b1; #1;
      chk("R7 sfr map", sel_sfr, exp_impl(a[7:0]));
    end
    @(negedge clk);
    rd_en = 1'b0;
    do_rd(8'h8E, 1'b0, d);
    chk("R7 8EH implemented", cap_sel_sfr, 1'b1);
  endtask

  task automatic t_timing();
    @(negedge clk);
    addr = 8'h40; ind_mode = 1'b0; wr_data = 8'hE1; wr_en = 1'b1; rd_en = 1'b1;
    #1;
    chk("R8 no commit before edge", (rd_data === 8'hE1), 1'b0);
    @(posedge clk); #1;
    chk("R8 commit after edge", rd_data, 8'hE1);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_lower();
    t_idle();
    t_sfr_direct();
    t_overlay();
    t_unimpl();
    t_map();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule